// File: doc/BRIEF.md
# Predicated Register-File Read Stage

This block is the front end of a two-sided load/store datapath. It holds the two 16-entry, 32-bit register files, called side A and side B. For each decoded instruction it does three things. It reads up to two source operands. It decides whether the instruction may execute, from one of five predicate registers. It flags operand or predicate encodings that the datapath cannot honour. Each source operand is either one 32-bit register or a 64-bit value built from two registers. The two-register form is accepted only when the two registers are a consecutive even/odd pair on one side.

Both register files have their own write port. Every result is registered, so an instruction presented in one cycle yields its operands, execute enable and illegal flag after the next rising clock edge. A read that meets a write to the same register in the same cycle sees the value held before the write. There is no forwarding path.

Top module: `prf_read_stage`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `out_exec` and `out_illegal` are 0, and every register of both sides reads as zero.
- R2: A narrow operand (`wide` = 0) returns, one cycle after `in_valid`, the named register zero-extended to 64 bits. Side code 0 selects side A and 1 selects side B.
- R3: A wide operand returns `{high register, low register}`: the odd register in bits 63:32 and the even register in bits 31:0.
- R4: A wide operand is legal only if the low index is even, the high index equals low index + 1, and both side codes are equal. Otherwise `out_illegal` = 1 and `out_exec` = 0.
- R5: The predicate code has 3 bits. 000 means unconditional. 001, 010 and 011 select B0, B1 and B2. 100 and 101 select A1 and A2.
- R6: With `in_pred_zero` = 0 the instruction executes when the selected register is nonzero. With `in_pred_zero` = 1 it executes when that register is zero.
- R7: Predicate codes 110 and 111 are reserved and give `out_illegal` = 1 and `out_exec` = 0.
- R8: A read of a register in the same cycle as a write to it returns the old value. The new value is returned from the following cycle on.
- R9: A cycle with `in_valid` = 0 gives `out_valid`, `out_exec` and `out_illegal` all 0 after the next edge.
- R10: For a narrow operand the high-register fields are ignored. They affect neither the value nor `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_en | input | 1 | Side A write enable |
| wa_idx | input | 4 | Side A write index |
| wa_data | input | 32 | Side A write data |
| wb_en | input | 1 | Side B write enable |
| wb_idx | input | 4 | Side B write index |
| wb_data | input | 32 | Side B write data |
| in_valid | input | 1 | Instruction present |
| in_pred | input | 3 | Predicate code |
| in_pred_zero | input | 1 | 1: execute when predicate register is zero |
| s1_wide | input | 1 | Source 1 is a register pair |
| s1_lo_side | input | 1 | Source 1 low register side |
| s1_lo_idx | input | 4 | Source 1 low register index |
| s1_hi_side | input | 1 | Source 1 high register side |
| s1_hi_idx | input | 4 | Source 1 high register index |
| s2_wide | input | 1 | Source 2 is a register pair |
| s2_lo_side | input | 1 | Source 2 low register side |
| s2_lo_idx | input | 4 | Source 2 low register index |
| s2_hi_side | input | 1 | Source 2 high register side |
| s2_hi_idx | input | 4 | Source 2 high register index |
| out_valid | output | 1 | Result present |
| out_op1 | output | 64 | Source 1 value |
| out_op2 | output | 64 | Source 2 value |
| out_exec | output | 1 | Instruction may execute |
| out_illegal | output | 1 | Illegal predicate code or register pair |

## Verification
A register write and an operand or predicate read of that same register can land in one cycle. The bench provokes this by driving the write port and an instruction that names the written register in the same cycle. It judges that the returned operand is the old contents, then reads again and expects the new contents. An illegal register pair and a reserved predicate code can also arrive together with a predicate that would otherwise allow execution. These cases are judged by execute enable staying low while the illegal flag rises.

// File: rtl/prf_pkg.sv
package prf_pkg;
    parameter int REG_W   = 32;
    parameter int REG_N   = 16;
    parameter int IDX_W   = $clog2(REG_N);
    parameter int PRED_W  = 3;
    parameter int N_SIDES = 2;
    parameter int N_RD    = 5;
    localparam int OP_W   = 2 * REG_W;

    // read port roles inside each bank
    localparam int RD_S1_LO = 0;
    localparam int RD_S1_HI = 1;
    localparam int RD_S2_LO = 2;
    localparam int RD_S2_HI = 3;
    localparam int RD_PRED  = 4;

    typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

    typedef enum logic [PRED_W-1:0] {
        PR_ALWAYS = 3'd0,
        PR_B0     = 3'd1,
        PR_B1     = 3'd2,
        PR_B2     = 3'd3,
        PR_A1     = 3'd4,
        PR_A2     = 3'd5,
        PR_RSV6   = 3'd6,
        PR_RSV7   = 3'd7
    } pred_e;

    typedef struct packed {
        logic             wide;
        side_e            lo_side;
        logic [IDX_W-1:0] lo_idx;
        side_e            hi_side;
        logic [IDX_W-1:0] hi_idx;
    } opnd_t;

    typedef struct packed {
        logic             uses_reg;
        logic             reserved;
        side_e            side;
        logic [IDX_W-1:0] idx;
    } pred_sel_t;

    function automatic pred_sel_t decode_pred(input pred_e code);
        pred_sel_t s;
        s = '{uses_reg: 1'b1, reserved: 1'b0, side: SIDE_B, idx: '0};
        unique case (code)
            PR_ALWAYS: s.uses_reg = 1'b0;
            PR_B0:     s.idx = IDX_W'(0);
            PR_B1:     s.idx = IDX_W'(1);
            PR_B2:     s.idx = IDX_W'(2);
            PR_A1:     begin s.side = SIDE_A; s.idx = IDX_W'(1); end
            PR_A2:     begin s.side = SIDE_A; s.idx = IDX_W'(2); end
            default:   begin s.uses_reg = 1'b0; s.reserved = 1'b1; end
        endcase
        return s;
    endfunction

    function automatic logic pair_legal(input opnd_t o);
        return (o.lo_idx[0] == 1'b0) &&
               (o.hi_idx == o.lo_idx + IDX_W'(1)) &&
               (o.hi_side == o.lo_side);
    endfunction
endpackage

// File: rtl/prf_bank.sv
module prf_bank
    import prf_pkg::*;
#(
    parameter int NRD = N_RD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr [NRD],
    output logic [REG_W-1:0] rdata [NRD]
);
    logic [REG_W-1:0] mem [REG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end

    // R8: a write is visible in storage right after its edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/prf_opnd.sv
module prf_opnd
    import prf_pkg::*;
(
    input  opnd_t            sel,
    input  logic [REG_W-1:0] lo_val [N_SIDES],
    input  logic [REG_W-1:0] hi_val [N_SIDES],
    output logic [OP_W-1:0]  value,
    output logic             bad
);
    logic [REG_W-1:0] lo_w, hi_w;

    always_comb begin
        lo_w = lo_val[sel.lo_side];
        hi_w = hi_val[sel.hi_side];
        if (sel.wide) begin
            value = {hi_w, lo_w};
            bad   = !pair_legal(sel);
        end else begin
            value = {{REG_W{1'b0}}, lo_w};
            bad   = 1'b0;
        end
    end
endmodule

// File: rtl/prf_pred.sv
module prf_pred
    import prf_pkg::*;
(
    input  pred_e            code,
    input  logic             zero_sense,
    input  logic [REG_W-1:0] side_val [N_SIDES],
    output logic [IDX_W-1:0] ridx,
    output logic             cond,
    output logic             reserved
);
    pred_sel_t s;
    logic      nz;

    always_comb begin
        s        = decode_pred(code);
        ridx     = s.idx;
        reserved = s.reserved;
        nz       = |side_val[s.side];
        if (!s.uses_reg) cond = !s.reserved;
        else             cond = nz ^ zero_sense;
    end
endmodule

// File: rtl/prf_read_stage.sv
module prf_read_stage
    import prf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wa_en,
    input  logic [IDX_W-1:0]   wa_idx,
    input  logic [REG_W-1:0]   wa_data,
    input  logic               wb_en,
    input  logic [IDX_W-1:0]   wb_idx,
    input  logic [REG_W-1:0]   wb_data,
    input  logic               in_valid,
    input  logic [PRED_W-1:0]  in_pred,
    input  logic               in_pred_zero,
    input  logic               s1_wide,
    input  logic               s1_lo_side,
    input  logic [IDX_W-1:0]   s1_lo_idx,
    input  logic               s1_hi_side,
    input  logic [IDX_W-1:0]   s1_hi_idx,
    input  logic               s2_wide,
    input  logic               s2_lo_side,
    input  logic [IDX_W-1:0]   s2_lo_idx,
    input  logic               s2_hi_side,
    input  logic [IDX_W-1:0]   s2_hi_idx,
    output logic               out_valid,
    output logic [OP_W-1:0]    out_op1,
    output logic [OP_W-1:0]    out_op2,
    output logic               out_exec,
    output logic               out_illegal
);
    opnd_t            src1, src2;
    logic             wr_en   [N_SIDES];
    logic [IDX_W-1:0] wr_idx  [N_SIDES];
    logic [REG_W-1:0] wr_data [N_SIDES];
    logic [IDX_W-1:0] raddr   [N_SIDES][N_RD];
    logic [REG_W-1:0] rdata   [N_SIDES][N_RD];
    logic [REG_W-1:0] s1_lo_v [N_SIDES], s1_hi_v [N_SIDES];
    logic [REG_W-1:0] s2_lo_v [N_SIDES], s2_hi_v [N_SIDES];
    logic [REG_W-1:0] pred_v  [N_SIDES];
    logic [IDX_W-1:0] pred_idx;
    logic [OP_W-1:0]  op1_nx, op2_nx;
    logic             bad1, bad2, cond, rsv, ill_nx;

    assign src1 = '{wide: s1_wide, lo_side: side_e'(s1_lo_side), lo_idx: s1_lo_idx,
                    hi_side: side_e'(s1_hi_side), hi_idx: s1_hi_idx};
    assign src2 = '{wide: s2_wide, lo_side: side_e'(s2_lo_side), lo_idx: s2_lo_idx,
                    hi_side: side_e'(s2_hi_side), hi_idx: s2_hi_idx};

    assign wr_en[SIDE_A]   = wa_en;
    assign wr_idx[SIDE_A]  = wa_idx;
    assign wr_data[SIDE_A] = wa_data;
    assign wr_en[SIDE_B]   = wb_en;
    assign wr_idx[SIDE_B]  = wb_idx;
    assign wr_data[SIDE_B] = wb_data;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        assign raddr[s][RD_S1_LO] = src1.lo_idx;
        assign raddr[s][RD_S1_HI] = src1.hi_idx;
        assign raddr[s][RD_S2_LO] = src2.lo_idx;
        assign raddr[s][RD_S2_HI] = src2.hi_idx;
        assign raddr[s][RD_PRED]  = pred_idx;

        prf_bank #(.NRD(N_RD)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en[s]),
            .widx  (wr_idx[s]),
            .wdata (wr_data[s]),
            .raddr (raddr[s]),
            .rdata (rdata[s])
        );

        assign s1_lo_v[s] = rdata[s][RD_S1_LO];
        assign s1_hi_v[s] = rdata[s][RD_S1_HI];
        assign s2_lo_v[s] = rdata[s][RD_S2_LO];
        assign s2_hi_v[s] = rdata[s][RD_S2_HI];
        assign pred_v[s]  = rdata[s][RD_PRED];
    end

    prf_opnd u_op1 (.sel(src1), .lo_val(s1_lo_v), .hi_val(s1_hi_v), .value(op1_nx), .bad(bad1));
    prf_opnd u_op2 (.sel(src2), .lo_val(s2_lo_v), .hi_val(s2_hi_v), .value(op2_nx), .bad(bad2));

    prf_pred u_pred (
        .code       (pred_e'(in_pred)),
        .zero_sense (in_pred_zero),
        .side_val   (pred_v),
        .ridx       (pred_idx),
        .cond       (cond),
        .reserved   (rsv)
    );

    assign ill_nx = rsv | bad1 | bad2;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_op1     <= '0;
            out_op2     <= '0;
            out_exec    <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_op1     <= op1_nx;
            out_op2     <= op2_nx;
            out_exec    <= in_valid & ~ill_nx & cond;
            out_illegal <= in_valid & ill_nx;
        end
    end

    // R7: reserved predicate codes never execute
    p_reserved_pred_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pred[2:1] == 2'b11) |=> (out_illegal && !out_exec));

    // R9: idle cycle produces a quiet result
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_exec && !out_illegal));

    // R5: unconditional with narrow operands always executes
    p_uncond_exec_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pred == 3'b000 && !s1_wide && !s2_wide) |=> out_exec);

    // R2: narrow operand has a zero upper word
    p_narrow_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !s1_wide) |=> out_op1[OP_W-1:REG_W] == '0);

    // R4: an odd low index makes a pair illegal
    p_odd_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && s2_wide && s2_lo_idx[0]) |=> (out_illegal && !out_exec));
endmodule

// File: tb/tb_prf_read_stage.sv
`timescale 1ns/1ps
module tb_prf_read_stage;
    logic        clk = 1'b0;
    logic        rst;
    logic        wa_en, wb_en;
    logic [3:0]  wa_idx, wb_idx;
    logic [31:0] wa_data, wb_data;
    logic        in_valid, in_pred_zero;
    logic [2:0]  in_pred;
    logic        s1_wide, s1_lo_side, s1_hi_side, s2_wide, s2_lo_side, s2_hi_side;
    logic [3:0]  s1_lo_idx, s1_hi_idx, s2_lo_idx, s2_hi_idx;
    logic        out_valid, out_exec, out_illegal;
    logic [63:0] out_op1, out_op2;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] ref_rf [2][16];

    always #2.5 clk = ~clk;

    prf_read_stage dut (
        .clk(clk), .rst(rst),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .in_valid(in_valid), .in_pred(in_pred), .in_pred_zero(in_pred_zero),
        .s1_wide(s1_wide), .s1_lo_side(s1_lo_side), .s1_lo_idx(s1_lo_idx),
        .s1_hi_side(s1_hi_side), .s1_hi_idx(s1_hi_idx),
        .s2_wide(s2_wide), .s2_lo_side(s2_lo_side), .s2_lo_idx(s2_lo_idx),
        .s2_hi_side(s2_hi_side), .s2_hi_idx(s2_hi_idx),
        .out_valid(out_valid), .out_op1(out_op1), .out_op2(out_op2),
        .out_exec(out_exec), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wa_en = 0; wb_en = 0; wa_idx = 0; wb_idx = 0; wa_data = 0; wb_data = 0;
        in_valid = 0; in_pred = 0; in_pred_zero = 0;
        s1_wide = 0; s1_lo_side = 0; s1_lo_idx = 0; s1_hi_side = 0; s1_hi_idx = 0;
        s2_wide = 0; s2_lo_side = 0; s2_lo_idx = 0; s2_hi_side = 0; s2_hi_idx = 0;
    endtask

    task automatic wr(input logic side, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        if (side) begin wb_en = 1; wb_idx = idx; wb_data = d; end
        else      begin wa_en = 1; wa_idx = idx; wa_data = d; end
        ref_rf[side][idx] = d;
        @(posedge clk); #1;
    endtask

    // drive one instruction; results are valid 1 ns after the next edge
    task automatic issue(input logic [2:0] pr, input logic pz,
                         input logic w1, input logic l1s, input logic [3:0] l1i,
                         input logic h1s, input logic [3:0] h1i,
                         input logic w2, input logic l2s, input logic [3:0] l2i,
                         input logic h2s, input logic [3:0] h2i);
        @(negedge clk);
        idle_inputs();
        in_valid = 1; in_pred = pr; in_pred_zero = pz;
        s1_wide = w1; s1_lo_side = l1s; s1_lo_idx = l1i; s1_hi_side = h1s; s1_hi_idx = h1i;
        s2_wide = w2; s2_lo_side = l2s; s2_lo_idx = l2i; s2_hi_side = h2s; s2_hi_idx = h2i;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        check("R1 valid", {63'b0, out_valid}, 64'd0);
        check("R1 exec", {63'b0, out_exec}, 64'd0);
        check("R1 illegal", {63'b0, out_illegal}, 64'd0);
        issue(3'b000, 0, 0, 0, 4'd7, 0, 0, 0, 1, 4'd12, 0, 0);
        check("R1 A7 zero", out_op1, 64'd0);
        check("R1 B12 zero", out_op2, 64'd0);
    endtask

    task automatic t_fill();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++)
                wr(s[0], i[3:0], 32'hA000_0000 ^ (s * 32'h0B00_0000) ^ (i * 32'h0101_0113));
    endtask

    task automatic t_narrow();
        issue(3'b000, 0, 0, 0, 4'd3, 0, 0, 0, 1, 4'd9, 0, 0);
        check("R2 valid", {63'b0, out_valid}, 64'd1);
        check("R2 A3", out_op1, {32'b0, ref_rf[0][3]});
        check("R2 B9", out_op2, {32'b0, ref_rf[1][9]});
        check("R2 exec", {63'b0, out_exec}, 64'd1);
    endtask

    task automatic t_wide();
        issue(3'b000, 0, 1, 0, 4'd4, 0, 4'd5, 1, 1, 4'd14, 1, 4'd15);
        check("R3 A5:A4", out_op1, {ref_rf[0][5], ref_rf[0][4]});
        check("R3 B15:B14", out_op2, {ref_rf[1][15], ref_rf[1][14]});
        check("R3 legal", {63'b0, out_illegal}, 64'd0);
    endtask

    task automatic t_bad_pair();
        issue(3'b000, 0, 1, 0, 4'd3, 0, 4'd4, 0, 0, 0, 0, 0);  // odd low
        check("R4 odd low ill", {63'b0, out_illegal}, 64'd1);
        check("R4 odd low exec", {63'b0, out_exec}, 64'd0);
        issue(3'b000, 0, 0, 0, 0, 0, 0, 1, 0, 4'd6, 1, 4'd7);  // mixed sides
        check("R4 mixed side ill", {63'b0, out_illegal}, 64'd1);
        check("R4 mixed side exec", {63'b0, out_exec}, 64'd0);
        issue(3'b000, 0, 1, 1, 4'd2, 1, 4'd5, 0, 0, 0, 0, 0);  // not consecutive
        check("R4 gap ill", {63'b0, out_illegal}, 64'd1);
    endtask

    task automatic t_pred();
        logic [31:0] pv [6];
        wr(1, 4'd0, 32'd0);  wr(1, 4'd1, 32'd5);  wr(1, 4'd2, 32'd0);
        wr(0, 4'd1, 32'h8000_0000); wr(0, 4'd2, 32'd0);
        wr(0, 4'd0, 32'd0);  wr(1, 4'd3, 32'd9);  // decoys outside the set
        pv[1] = 32'd0; pv[2] = 32'd5; pv[3] = 32'd0; pv[4] = 32'h8000_0000; pv[5] = 32'd0;
        for (int c = 1; c <= 5; c++) begin
            for (int z = 0; z < 2; z++) begin
                issue(c[2:0], z[0], 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
                check(z ? "R6 zero sense" : "R5 code map",
                      {63'b0, out_exec}, {63'b0, (pv[c] != 0) ^ z[0]});
            end
        end
        issue(3'b000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R5 unconditional", {63'b0, out_exec}, 64'd1);
    endtask

    task automatic t_reserved();
        issue(3'b110, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 code6 ill", {63'b0, out_illegal}, 64'd1);
        check("R7 code6 exec", {63'b0, out_exec}, 64'd0);
        issue(3'b111, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 code7 ill", {63'b0, out_illegal}, 64'd1);
        check("R7 code7 exec", {63'b0, out_exec}, 64'd0);
    endtask

    task automatic t_collision();
        logic [31:0] old_v, old_p;
        old_v = ref_rf[0][9];
        old_p = ref_rf[1][1];  // B1 = 5, predicate true under nonzero sense
        @(negedge clk);
        idle_inputs();
        wa_en = 1; wa_idx = 4'd9; wa_data = 32'hC0FF_EE01;
        wb_en = 1; wb_idx = 4'd1; wb_data = 32'd0;
        in_valid = 1; in_pred = 3'b010; in_pred_zero = 0;
        s1_lo_side = 0; s1_lo_idx = 4'd9;
        ref_rf[0][9] = 32'hC0FF_EE01; ref_rf[1][1] = 32'd0;
        @(posedge clk); #1;
        check("R8 old operand", out_op1, {32'b0, old_v});
        check("R8 old predicate", {63'b0, out_exec}, {63'b0, old_p != 0});
        issue(3'b010, 0, 0, 0, 4'd9, 0, 0, 0, 0, 0, 0, 0);
        check("R8 new operand", out_op1, {32'b0, ref_rf[0][9]});
        check("R8 new predicate", {63'b0, out_exec}, 64'd0);
    endtask

    task automatic t_idle();
        issue(3'b110, 0, 1, 0, 4'd1, 1, 4'd0, 0, 0, 0, 0, 0);
        @(negedge clk);
        idle_inputs();
        in_pred = 3'b111; s1_wide = 1; s1_lo_idx = 4'd3;
        @(posedge clk); #1;
        check("R9 valid low", {63'b0, out_valid}, 64'd0);
        check("R9 exec low", {63'b0, out_exec}, 64'd0);
        check("R9 illegal low", {63'b0, out_illegal}, 64'd0);
    endtask

    task automatic t_hi_ignored();
        issue(3'b000, 0, 0, 1, 4'd6, 0, 4'd3, 0, 0, 4'd8, 1, 4'd11);
        check("R10 op1 value", out_op1, {32'b0, ref_rf[1][6]});
        check("R10 op2 value", out_op2, {32'b0, ref_rf[0][8]});
        check("R10 not illegal", {63'b0, out_illegal}, 64'd0);
        check("R10 exec", {63'b0, out_exec}, 64'd1);
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++) ref_rf[s][i] = '0;
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        t_reset();
        t_fill();
        t_narrow();
        t_wide();
        t_bad_pair();
        t_hi_ignored();
        t_pred();
        t_reserved();
        t_collision();
        t_idle();
        @(negedge clk);
        idle_inputs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule